// File: doc/BRIEF.md
# Search Tree Manager for Monte Carlo Planning

This block keeps a Monte Carlo search tree in on-chip storage and carries out the tree bookkeeping of each planning iteration when a controller commands it. An iteration runs in a fixed order. First, a select command walks down from the root and returns a leaf. Next, an expand command attaches child nodes and their priors to that leaf. The controller then gets the leaf's value from an external evaluator. Last, a backpropagate command adds that value to every node on the path back to the root.

Each node holds a visit count, a signed value sum, a prior, the index of its parent, and a contiguous range of children. At each level of a select walk, a balanced comparator tree scores every child of the current node in one cycle and moves to the winner. When search ends, the controller reads the preferred action from a port that always shows the root child with the most visits.

Top module: `mcts_tree_engine`

## Requirements
- R1: After reset, or one cycle after an accepted clear command (op 1), the tree holds only the root (node 0) with zero statistics, `act_valid` is low and a select returns leaf 0. A clear raises `done` in cycle 1, where the command cycle is cycle 0.
- R2: Select (op 2) starts at node 0. At each node that has children it moves to the child with the highest score Q + (P*E)/(1+n). Q is the value sum divided by the visit count, truncated toward zero, and is 0 when the visit count is 0. P is the child's prior, E is `cmd_explore` as captured with the command, n is the child's visit count, and the division is integer. The walk stops at the first node with no children and reports that node on `leaf`.
- R3: When children have equal scores, select takes the one with the lowest child position.
- R4: A select that ends at depth d raises `done` in cycle d+2, and `busy` stays high until then.
- R5: Expand (op 3) of node `cmd_node` with `cmd_count` children (1 to 32) places them at consecutive indices starting at the free pointer. The free pointer is 1 after a clear. Child k gets prior `cmd_priors[8k+7:8k]` and zero statistics. `done` rises in cycle 1.
- R6: If the free pointer plus `cmd_count` would exceed the node capacity (4096), the expand raises `full_err` together with `done` and leaves the tree unchanged. A request that fills the capacity exactly is accepted.
- R7: Backpropagate (op 4) from `cmd_node` adds 1 to the visit count and adds the value to the value sum of each node from that node up to the root.
- R8: With `cmd_two_player` set, the value added flips sign at each level going up. The starting node receives it unchanged.
- R9: A backpropagation that starts at depth d takes four cycles per level and raises `done` in cycle 4d+5. `busy` is high from cycle 1 until `done`.
- R10: While idle, `act_valid` is high when the root has children, and `act_index` gives the child position with the highest visit count. Ties go to the lowest position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is low |
| cmd_op | input | 3 | 1 clear, 2 select, 3 expand, 4 backpropagate, 0 none |
| cmd_node | input | 12 | Node to expand or to start backpropagation from |
| cmd_explore | input | 8 | Exploration weight E for a select |
| cmd_count | input | 6 | Number of children to add on expand |
| cmd_priors | input | 256 | Child priors, 8 bits each, child 0 in the low bits |
| cmd_value | input | 16 | Signed leaf value for backpropagation |
| cmd_two_player | input | 1 | Flip the value's sign at each level |
| busy | output | 1 | A select or backpropagation walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| full_err | output | 1 | Expand refused for lack of space (with `done`) |
| leaf | output | 12 | Leaf found by the last select |
| act_valid | output | 1 | Root has children and the engine is idle |
| act_index | output | 5 | Root child position with the most visits |

## Verification
The checker assumes the controller issues commands only while `busy` is low and names only nodes that already exist. It also assumes a node is expanded at most once, and that visit counts and value sums never grow past their field widths. The bench drives every command through a task that waits for `done` before returning. It builds trees by hand, so each node index is known. Values stay small, and it fills storage only with fresh leaves that have never been expanded.

// File: rtl/mcts_pkg.sv
package mcts_pkg;

    localparam int CNT_W   = 16;
    localparam int VAL_W   = 16;
    localparam int PRI_W   = 8;
    localparam int EXP_W   = 8;
    localparam int SCORE_W = ((VAL_W > PRI_W + EXP_W) ? VAL_W : PRI_W + EXP_W) + 2;
    localparam int DIV_W   = ((PRI_W + EXP_W) > CNT_W + 1) ? PRI_W + EXP_W : CNT_W + 1;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_CLEAR    = 3'd1,
        OP_SELECT   = 3'd2,
        OP_EXPAND   = 3'd3,
        OP_BACKPROP = 3'd4
    } tree_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEL, ST_BP_RD, ST_BP_ADD, ST_BP_WR, ST_BP_NXT
    } eng_state_e;

    typedef struct packed {
        logic        [CNT_W-1:0] visits;
        logic signed [VAL_W-1:0] vsum;
        logic        [PRI_W-1:0] prior;
    } node_stat_t;

    // Mean value plus prior-weighted exploration bonus, integer arithmetic.
    function automatic logic signed [SCORE_W-1:0] ucb_score(node_stat_t s, logic [EXP_W-1:0] e);
        logic signed [SCORE_W-1:0] q, sum_x, cnt_x;
        logic [DIV_W-1:0] num, den, bonus;
        sum_x = SCORE_W'(s.vsum);
        cnt_x = SCORE_W'(s.visits);
        q     = (s.visits == '0) ? '0 : sum_x / cnt_x;
        num   = DIV_W'(s.prior) * DIV_W'(e);
        den   = DIV_W'(s.visits) + DIV_W'(1);
        bonus = num / den;
        return q + SCORE_W'(bonus);
    endfunction

endpackage

// File: rtl/mcts_argmax.sv
// Balanced comparator tree: valid entries beat invalid ones, the upper
// entry of a pair wins only when strictly larger, so ties keep the low index.
module mcts_argmax #(
    parameter int N = 32,
    parameter int W = 18,
    localparam int LV = $clog2(N)
) (
    input  logic [N-1:0]         valid,
    input  logic signed [W-1:0]  score [N],
    output logic [LV-1:0]        idx,
    output logic                 any
);

    for (genvar l = 0; l <= LV; l++) begin : g_lvl
        localparam int CNT = N >> l;
        logic signed [W-1:0] sc [CNT];
        logic [LV-1:0]       ix [CNT];
        logic [CNT-1:0]      vl;

        if (l == 0) begin : g_in
            for (genvar i = 0; i < N; i++) begin : g_leaf
                assign sc[i] = score[i];
                assign ix[i] = LV'(i);
            end
            assign vl = valid;
        end else begin : g_merge
            for (genvar i = 0; i < CNT; i++) begin : g_pair
                logic take_hi;
                assign take_hi = g_lvl[l-1].vl[2*i+1] &&
                                 (!g_lvl[l-1].vl[2*i] ||
                                  (g_lvl[l-1].sc[2*i+1] > g_lvl[l-1].sc[2*i]));
                assign sc[i] = take_hi ? g_lvl[l-1].sc[2*i+1] : g_lvl[l-1].sc[2*i];
                assign ix[i] = take_hi ? g_lvl[l-1].ix[2*i+1] : g_lvl[l-1].ix[2*i];
                assign vl[i] = g_lvl[l-1].vl[2*i] | g_lvl[l-1].vl[2*i+1];
            end
        end
    end

    assign idx = g_lvl[LV].ix[0];
    assign any = g_lvl[LV].vl[0];

endmodule

// File: rtl/mcts_node_store.sv
// Node storage: one lookup port that also exposes the full child window,
// a bulk child-allocation write port and a statistics write port.
module mcts_node_store
    import mcts_pkg::*;
#(
    parameter int NODES    = 4096,
    parameter int MAX_KIDS = 32,
    localparam int AW = $clog2(NODES),
    localparam int KW = $clog2(MAX_KIDS) + 1
) (
    input  logic                      clk,
    input  logic                      clear,
    input  logic [AW-1:0]             look_node,
    output logic [AW-1:0]             look_parent,
    output logic [AW-1:0]             look_first,
    output logic [KW-1:0]             look_nkids,
    output node_stat_t                look_stat,
    output node_stat_t                kid_stat [MAX_KIDS],
    output logic [MAX_KIDS-1:0]       kid_valid,
    input  logic                      exp_we,
    input  logic [AW-1:0]             exp_node,
    input  logic [AW-1:0]             exp_base,
    input  logic [KW-1:0]             exp_count,
    input  logic [MAX_KIDS*PRI_W-1:0] exp_priors,
    input  logic                      st_we,
    input  logic [AW-1:0]             st_node,
    input  node_stat_t                st_val
);

    node_stat_t        stat_q   [NODES];
    logic [AW-1:0]     parent_q [NODES];
    logic [AW-1:0]     first_q  [NODES];
    logic [KW-1:0]     nkids_q  [NODES];

    always_ff @(posedge clk) begin
        if (clear) begin
            stat_q[0]   <= '0;
            parent_q[0] <= '0;
            first_q[0]  <= '0;
            nkids_q[0]  <= '0;
        end else begin
            if (exp_we) begin
                first_q[exp_node] <= exp_base;
                nkids_q[exp_node] <= exp_count;
                for (int k = 0; k < MAX_KIDS; k++) begin
                    if (KW'(k) < exp_count) begin
                        stat_q[exp_base + AW'(k)]   <= '{visits: '0, vsum: '0,
                                                         prior: exp_priors[k*PRI_W +: PRI_W]};
                        parent_q[exp_base + AW'(k)] <= exp_node;
                        first_q[exp_base + AW'(k)]  <= '0;
                        nkids_q[exp_base + AW'(k)]  <= '0;
                    end
                end
            end
            if (st_we) begin
                stat_q[st_node] <= st_val;
            end
        end
    end

    assign look_parent = parent_q[look_node];
    assign look_first  = first_q[look_node];
    assign look_nkids  = nkids_q[look_node];
    assign look_stat   = stat_q[look_node];

    for (genvar k = 0; k < MAX_KIDS; k++) begin : g_window
        assign kid_stat[k]  = stat_q[first_q[look_node] + AW'(k)];
        assign kid_valid[k] = KW'(k) < nkids_q[look_node];
    end

endmodule

// File: rtl/mcts_tree_engine.sv
module mcts_tree_engine
    import mcts_pkg::*;
#(
    parameter int NODES    = 4096,
    parameter int MAX_KIDS = 32,
    localparam int AW = $clog2(NODES),
    localparam int KW = $clog2(MAX_KIDS) + 1,
    localparam int IW = $clog2(MAX_KIDS),
    localparam int FW = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic [2:0]                cmd_op,
    input  logic [AW-1:0]             cmd_node,
    input  logic [EXP_W-1:0]          cmd_explore,
    input  logic [KW-1:0]             cmd_count,
    input  logic [MAX_KIDS*PRI_W-1:0] cmd_priors,
    input  logic signed [VAL_W-1:0]   cmd_value,
    input  logic                      cmd_two_player,
    output logic                      busy,
    output logic                      done,
    output logic                      full_err,
    output logic [AW-1:0]             leaf,
    output logic                      act_valid,
    output logic [IW-1:0]             act_index
);

    eng_state_e               state;
    logic [AW-1:0]            cur, up_q;
    logic [EXP_W-1:0]         explore_q;
    logic signed [VAL_W-1:0]  val_q;
    logic                     two_q;
    node_stat_t               work_q;
    logic [FW-1:0]            free_ptr;

    logic                     accept, fits, legal, exp_we, clear_w;
    logic [AW-1:0]            look_node, look_parent, look_first;
    logic [KW-1:0]            look_nkids;
    node_stat_t               look_stat;
    node_stat_t               kid_stat [MAX_KIDS];
    logic [MAX_KIDS-1:0]      kid_valid;
    logic signed [SCORE_W-1:0] ucb [MAX_KIDS];
    logic signed [SCORE_W-1:0] vis [MAX_KIDS];
    logic [IW-1:0]            sel_idx, vis_idx;
    logic                     sel_any, vis_any;

    assign busy      = (state != ST_IDLE);
    assign accept    = cmd_valid && !busy;
    assign fits      = ({1'b0, free_ptr} + (FW+1)'(cmd_count)) <= (FW+1)'(NODES);
    assign legal     = cmd_count <= KW'(MAX_KIDS);
    assign exp_we    = accept && (tree_op_e'(cmd_op) == OP_EXPAND) && fits && legal;
    assign clear_w   = rst || (accept && (tree_op_e'(cmd_op) == OP_CLEAR));
    assign look_node = busy ? cur : '0;

    mcts_node_store #(.NODES(NODES), .MAX_KIDS(MAX_KIDS)) u_store (
        .clk        (clk),
        .clear      (clear_w),
        .look_node  (look_node),
        .look_parent(look_parent),
        .look_first (look_first),
        .look_nkids (look_nkids),
        .look_stat  (look_stat),
        .kid_stat   (kid_stat),
        .kid_valid  (kid_valid),
        .exp_we     (exp_we),
        .exp_node   (cmd_node),
        .exp_base   (free_ptr[AW-1:0]),
        .exp_count  (cmd_count),
        .exp_priors (cmd_priors),
        .st_we      (state == ST_BP_WR),
        .st_node    (cur),
        .st_val     (work_q)
    );

    for (genvar k = 0; k < MAX_KIDS; k++) begin : g_score
        assign ucb[k] = ucb_score(kid_stat[k], explore_q);
        assign vis[k] = SCORE_W'(kid_stat[k].visits);
    end

    mcts_argmax #(.N(MAX_KIDS), .W(SCORE_W)) u_pick_ucb (
        .valid(kid_valid), .score(ucb), .idx(sel_idx), .any(sel_any)
    );

    mcts_argmax #(.N(MAX_KIDS), .W(SCORE_W)) u_pick_visits (
        .valid(kid_valid), .score(vis), .idx(vis_idx), .any(vis_any)
    );

    assign act_valid = !busy && vis_any;
    assign act_index = vis_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            up_q      <= '0;
            explore_q <= '0;
            val_q     <= '0;
            two_q     <= 1'b0;
            work_q    <= '0;
            free_ptr  <= FW'(1);
            done      <= 1'b0;
            full_err  <= 1'b0;
            leaf      <= '0;
        end else begin
            done     <= 1'b0;
            full_err <= 1'b0;
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    case (tree_op_e'(cmd_op))
                        OP_CLEAR: begin
                            free_ptr <= FW'(1);
                            done     <= 1'b1;
                        end
                        OP_SELECT: begin
                            cur       <= '0;
                            explore_q <= cmd_explore;
                            state     <= ST_SEL;
                        end
                        OP_EXPAND: begin
                            if (fits && legal) free_ptr <= free_ptr + FW'(cmd_count);
                            full_err <= !fits;
                            done     <= 1'b1;
                        end
                        OP_BACKPROP: begin
                            cur   <= cmd_node;
                            val_q <= cmd_value;
                            two_q <= cmd_two_player;
                            state <= ST_BP_RD;
                        end
                        default: ;
                    endcase
                end
                ST_SEL: begin
                    if (!sel_any) begin
                        leaf  <= cur;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cur <= look_first + AW'(sel_idx);
                    end
                end
                ST_BP_RD: begin
                    work_q <= look_stat;
                    up_q   <= look_parent;
                    state  <= ST_BP_ADD;
                end
                ST_BP_ADD: begin
                    work_q.visits <= work_q.visits + CNT_W'(1);
                    work_q.vsum   <= work_q.vsum + val_q;
                    state         <= ST_BP_WR;
                end
                ST_BP_WR: state <= ST_BP_NXT;
                ST_BP_NXT: begin
                    if (cur == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cur   <= up_q;
                        if (two_q) val_q <= -val_q;
                        state <= ST_BP_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mcts_tree_checker.sv
module mcts_tree_checker #(
    parameter int NODES = 4096,
    parameter int AW    = 12,
    parameter int FW    = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic          busy,
    input logic          done,
    input logic          full_err,
    input logic          act_valid,
    input logic [FW-1:0] free_ptr
);

    // R6: the allocation pointer never passes capacity and never drops below 1
    a_r6_free_bound: assert property (@(posedge clk) disable iff (rst)
        (free_ptr >= FW'(1)) && (free_ptr <= FW'(NODES)));

    // R6: a refused expand leaves allocation untouched
    a_r6_full_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        full_err |-> (free_ptr == $past(free_ptr)));

    // R1: clear restores the single-root tree in one cycle
    a_r1_clear_root: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 3'd1) |=> (free_ptr == FW'(1) && done && !busy));

    // R5: expand completes in the cycle after it is taken
    a_r5_expand_done: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 3'd3) |=> (done && !busy));

    // R4 and R9: select and backpropagation walks hold busy before finishing
    a_r9_walk_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && (cmd_op == 3'd2 || cmd_op == 3'd4)) |=> (busy && !done));

    // R10: the chosen action is only offered while idle
    a_r10_act_idle: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> !busy);

endmodule

bind mcts_tree_engine mcts_tree_checker #(.NODES(NODES), .AW(AW), .FW(FW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .busy     (busy),
    .done     (done),
    .full_err (full_err),
    .act_valid(act_valid),
    .free_ptr (free_ptr)
);

// File: tb/tb_mcts_tree_engine.sv
module tb_mcts_tree_engine;
    import mcts_pkg::*;

    localparam int NODES    = 4096;
    localparam int MAX_KIDS = 32;
    localparam int AW       = $clog2(NODES);
    localparam int KW       = $clog2(MAX_KIDS) + 1;
    localparam int IW       = $clog2(MAX_KIDS);
    localparam int PV_W     = MAX_KIDS * PRI_W;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    cmd_valid;
    logic [2:0]              cmd_op;
    logic [AW-1:0]           cmd_node;
    logic [EXP_W-1:0]        cmd_explore;
    logic [KW-1:0]           cmd_count;
    logic [PV_W-1:0]         cmd_priors;
    logic signed [VAL_W-1:0] cmd_value;
    logic                    cmd_two_player;
    logic                    busy, done, full_err, act_valid;
    logic [AW-1:0]           leaf;
    logic [IW-1:0]           act_index;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mcts_tree_engine #(.NODES(NODES), .MAX_KIDS(MAX_KIDS)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_node(cmd_node), .cmd_explore(cmd_explore), .cmd_count(cmd_count),
        .cmd_priors(cmd_priors), .cmd_value(cmd_value), .cmd_two_player(cmd_two_player),
        .busy(busy), .done(done), .full_err(full_err), .leaf(leaf),
        .act_valid(act_valid), .act_index(act_index)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [PV_W-1:0] flat_pri(input int base, input int hi_pos, input int hi_val);
        logic [PV_W-1:0] p;
        for (int k = 0; k < MAX_KIDS; k++) p[k*PRI_W +: PRI_W] = PRI_W'(base);
        p[hi_pos*PRI_W +: PRI_W] = PRI_W'(hi_val);
        return p;
    endfunction

    // Issue one command; cyc = cycle (command cycle is 0) in which done is seen.
    task automatic issue(input tree_op_e op, input int node, input int ex, input int cnt,
                         input logic [PV_W-1:0] pri, input int val, input bit two,
                         output int cyc, output int lf, output bit full, output bit busy1);
        @(negedge clk);
        cmd_valid      = 1'b1;
        cmd_op         = op;
        cmd_node       = AW'(node);
        cmd_explore    = EXP_W'(ex);
        cmd_count      = KW'(cnt);
        cmd_priors     = pri;
        cmd_value      = VAL_W'(val);
        cmd_two_player = two;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = OP_NOP;
        cyc   = 1;
        busy1 = busy;
        while (!done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        lf   = leaf;
        full = full_err;
    endtask

    task automatic t_reset;
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "act_valid after reset", act_valid, 0);
        chk("R1", "done after reset", done, 0);
    endtask

    task automatic t_expand_select;
        int c, lf; bit f, b; logic [PV_W-1:0] p;
        issue(OP_SELECT, 0, 5, 0, '0, 0, 0, c, lf, f, b);
        chk("R1", "leaf of empty tree", lf, 0);
        chk("R4", "root select cycle", c, 2);
        p = '0;
        p[0*8 +: 8] = 8'd10; p[1*8 +: 8] = 8'd40; p[2*8 +: 8] = 8'd40; p[3*8 +: 8] = 8'd20;
        issue(OP_EXPAND, 0, 0, 4, p, 0, 0, c, lf, f, b);
        chk("R5", "expand done cycle", c, 1);
        chk("R5", "expand no full", f, 0);
        chk("R10", "act_valid once root has kids", act_valid, 1);
        chk("R10", "all-zero visits pick position 0", act_index, 0);
        issue(OP_SELECT, 0, 10, 0, '0, 0, 0, c, lf, f, b);
        chk("R3", "equal scores take lower child", lf, 2);
        chk("R4", "depth-1 select cycle", c, 3);
    endtask

    task automatic t_backprop_single;
        int c, lf; bit f, b;
        issue(OP_BACKPROP, 2, 0, 0, '0, 5, 0, c, lf, f, b);
        chk("R9", "depth-1 backprop cycle", c, 9);
        chk("R9", "busy during backprop", b, 1);
        chk("R10", "most visited root child", act_index, 1);
        issue(OP_SELECT, 0, 10, 0, '0, 0, 0, c, lf, f, b);
        chk("R2", "visited child loses to bonus", lf, 3);
    endtask

    task automatic t_two_player;
        int c, lf; bit f, b; logic [PV_W-1:0] p;
        p = '0;
        p[0*8 +: 8] = 8'd50; p[1*8 +: 8] = 8'd60;
        issue(OP_EXPAND, 3, 0, 2, p, 0, 0, c, lf, f, b);
        chk("R5", "second expand no full", f, 0);
        issue(OP_SELECT, 0, 1, 0, '0, 0, 0, c, lf, f, b);
        chk("R2", "two-level descent leaf", lf, 6);
        chk("R4", "depth-2 select cycle", c, 4);
        issue(OP_BACKPROP, 6, 0, 0, '0, 7, 1, c, lf, f, b);
        chk("R9", "depth-2 backprop cycle", c, 13);
        issue(OP_SELECT, 0, 0, 0, '0, 0, 0, c, lf, f, b);
        chk("R8", "negated value steers away", lf, 2);
        chk("R10", "visit tie picks lower position", act_index, 1);
        issue(OP_BACKPROP, 5, 0, 0, '0, 1, 0, c, lf, f, b);
        chk("R7", "visits accumulate on ancestor", act_index, 2);
    endtask

    task automatic t_full_tree;
        int c, lf, bad; bit f, b; logic [PV_W-1:0] p;
        issue(OP_CLEAR, 0, 0, 0, '0, 0, 0, c, lf, f, b);
        chk("R1", "clear done cycle", c, 1);
        chk("R1", "act_valid after clear", act_valid, 0);
        issue(OP_SELECT, 0, 3, 0, '0, 0, 0, c, lf, f, b);
        chk("R1", "select after clear", lf, 0);
        issue(OP_EXPAND, 0, 0, 32, flat_pri(1, 5, 9), 0, 0, c, lf, f, b);
        bad = 0;
        for (int m = 0; m < 126; m++) begin
            issue(OP_EXPAND, (m == 0) ? 2 : 32 + m, 0, 32, flat_pri(1, 0, 1), 0, 0, c, lf, f, b);
            if (f) bad++;
        end
        chk("R6", "fills below capacity accepted", bad, 0);
        issue(OP_EXPAND, 6, 0, 32, flat_pri(1, 3, 50), 0, 0, c, lf, f, b);
        chk("R6", "overflow flagged", f, 1);
        chk("R6", "overflow done cycle", c, 1);
        issue(OP_SELECT, 0, 1, 0, '0, 0, 0, c, lf, f, b);
        chk("R6", "refused node stays a leaf", lf, 6);
        issue(OP_EXPAND, 6, 0, 31, flat_pri(1, 3, 50), 0, 0, c, lf, f, b);
        chk("R6", "exact fill accepted", f, 0);
        issue(OP_SELECT, 0, 1, 0, '0, 0, 0, c, lf, f, b);
        chk("R5", "last block placed at free pointer", lf, 4068);
        issue(OP_EXPAND, 7, 0, 1, flat_pri(1, 0, 1), 0, 0, c, lf, f, b);
        chk("R6", "no room left", f, 1);
        issue(OP_CLEAR, 0, 0, 0, '0, 0, 0, c, lf, f, b);
        chk("R1", "act_valid after second clear", act_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = OP_NOP; cmd_node = '0; cmd_explore = '0;
        cmd_count = '0; cmd_priors = '0; cmd_value = '0; cmd_two_player = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_expand_select();
        t_backprop_single();
        t_two_player();
        t_full_tree();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule